// File: doc/BRIEF.md
# Converter Leg Fault Supervisor

This block watches every switching leg of a drive made of two paralleled single-phase rectifiers feeding one DC link, plus a three-phase inverter. Each clock it compares the gate command of each leg with the sign of that leg's measured pole voltage. A leg whose mismatches persist past a hysteresis count is declared faulty. The fault is labelled either as a shorted device or as an open device, and the converter is switched to one of four operating configurations.

When a rectifier leg fails, the whole rectifier holding that leg is taken out of service. For an open device every switch of that rectifier is held off. For a shorted device every switch of that rectifier is driven on, so that its fuses clear. The surviving rectifier then carries the whole grid current. When an inverter leg fails, its connecting thyristor is fired and the failed leg is gated off. One leg of rectifier B is parked and a second leg of rectifier B takes over the failed phase's gate command. The block sits between the modulator and the gate drivers: it passes commands through while healthy and overrides them once a configuration has been chosen.

Top module: `fault_supervisor`

## Requirements
- R1: After reset the configuration code is 0, there are no fault flags, every thyristor fire line is low and both rectifier-active bits are 1.
- R2: A leg's fault flag rises at the clock edge that ends the fourth consecutive mismatch sample (TRIP_COUNT = 4) and not earlier. A mismatch means the command bit differs from the measured bit. Only reset clears the flag; the clear input does not.
- R3: Each leg keeps a count of evidence that rises by one on a mismatch and falls by one, not below zero, on a match. A run of mismatches broken by a match needs correspondingly more samples to trip.
- R4: A fault whose tripping sample has command 1 and measurement 0 sets the leg's short flag to 1. A fault whose tripping sample has command 0 and measurement 1 leaves the short flag at 0, which means an open device.
- R5: Legs are numbered 0-3 for rectifier A, 4-7 for rectifier B and 8-10 for the inverter. On the clock edge after a fault flag rises, the configuration code becomes 1 for a rectifier A leg, 2 for a rectifier B leg or 3 for an inverter leg. The code never changes while no flag is set.
- R6: In configuration 1 or 2 after an open fault, the high and low gates of all four legs of the failed rectifier are 0.
- R7: In configuration 1 or 2 after a short fault, the high and low gates of all four legs of the failed rectifier are 1.
- R8: In configuration 3 the fire line of the failed inverter leg is the only one high, and that leg's gates are both 0. Leg 4 is parked with both gates 0. Leg 5 carries the failed leg's command, with its high gate equal to that command and its low gate equal to the inverse.
- R9: The rectifier-active output uses bit 0 for rectifier A and bit 1 for rectifier B. It is 2'b11 when healthy, 2'b10 in configuration 1, and 2'b01 in configurations 2 and 3.
- R10: The first fault to trip fixes the configuration, and later faults only set their own flags. If faults trip on the same edge, the lowest-numbered leg wins.
- R11: The clear input returns the configuration to 0 on the next edge. A fault tripping afterwards selects a new configuration.
- R12: Any gate not overridden by R6-R8 follows its command, with the high gate equal to the command bit and the low gate equal to its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pole sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Return configuration to healthy |
| cmd | input | 11 | Commanded pole state per leg (1 = upper device on) |
| meas | input | 11 | Measured pole-voltage sign per leg (1 = positive) |
| gate_hi | output | 11 | Upper-device gate per leg after override |
| gate_lo | output | 11 | Lower-device gate per leg after override |
| scr_fire | output | 3 | Thyristor fire line per inverter leg |
| rect_active | output | 2 | Rectifier in service (bit 0 A, bit 1 B) |
| cfg | output | 2 | Configuration code 0-3 |
| fault_flag | output | 11 | Latched fault per leg |
| fault_short | output | 11 | Fault type per leg (1 = short) |

## Verification
Each of the eleven legs is faulted in turn with both mismatch polarities. This tells apart the rectifier A, rectifier B and inverter mappings, and also the off-isolation, on-isolation and substitution overrides. Each case is checked under two complementary command patterns, so that a gate stuck at a constant or wired to the wrong leg shows up. Broken and decaying mismatch runs separate a true up-down count from a count that resets or never decays. Staggered and simultaneous faults, followed by a clear, separate first-fault priority and lowest-index arbitration from the behaviour of a configuration that follows the latest fault.

// File: rtl/fsup_pkg.sv
// Shared types for the converter leg fault supervisor.
package fsup_pkg;
    // Operating configuration of the converter; the code is visible at the port.
    typedef enum logic [1:0] {
        CFG_HEALTHY = 2'd0,
        CFG_RECT_A  = 2'd1,
        CFG_RECT_B  = 2'd2,
        CFG_INV     = 2'd3
    } cfg_e;
endpackage

// File: rtl/fsup_leg_monitor.sv
// One leg's fault detector: an up/down evidence counter with hysteresis.
// It raises a sticky flag and a one-cycle trip pulse when the count
// reaches TRIP_COUNT, and it records the mismatch polarity of that sample.
// Assumes one pole sample per clock.
module fsup_leg_monitor #(
    parameter int TRIP_COUNT = 4,
    localparam int CNT_W = $clog2(TRIP_COUNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic meas,
    output logic flag,
    output logic short_o,
    output logic trip
);
    logic [CNT_W-1:0] cnt;
    logic             miss;
    logic             reach;

    assign miss  = cmd ^ meas;
    assign reach = miss && (cnt == CNT_W'(TRIP_COUNT - 1)) && !flag;

    // Evidence counter: climb on mismatch, decay on match, saturate at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (miss && cnt != CNT_W'(TRIP_COUNT))
            cnt <= cnt + 1'b1;
        else if (!miss && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Latch flag and fault type; pulse trip for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            short_o <= 1'b0;
            trip    <= 1'b0;
        end else begin
            trip <= reach;
            if (reach) begin
                flag    <= 1'b1;
                short_o <= cmd & ~meas;
            end
        end
    end
endmodule

// File: rtl/fsup_cfg_fsm.sv
// Configuration state machine. The first trip pulse seen while healthy
// picks the configuration; when several trip together, the lowest leg index
// wins. The state is held until clr. It assumes the leg order: rectifier A,
// then rectifier B, then inverter.
module fsup_cfg_fsm
    import fsup_pkg::*;
#(
    parameter int RECT_LEGS = 4,
    parameter int INV_LEGS  = 3,
    localparam int NLEG  = 2 * RECT_LEGS + INV_LEGS,
    localparam int IDX_W = $clog2(NLEG),
    localparam int INV_W = (INV_LEGS > 1) ? $clog2(INV_LEGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NLEG-1:0]  trip,
    input  logic [NLEG-1:0]  short_in,
    output cfg_e             cfg,
    output logic             iso_short,
    output logic [INV_W-1:0] inv_sel
);
    logic             any_trip;
    logic [IDX_W-1:0] hit;

    // Lowest-index arbitration among simultaneous trips.
    always_comb begin
        any_trip = 1'b0;
        hit      = '0;
        for (int i = NLEG - 1; i >= 0; i--) begin
            if (trip[i]) begin
                any_trip = 1'b1;
                hit      = IDX_W'(i);
            end
        end
    end

    // State register: enter a fault configuration only from healthy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= CFG_HEALTHY;
            iso_short <= 1'b0;
            inv_sel   <= '0;
        end else if (clr) begin
            cfg <= CFG_HEALTHY;
        end else if (cfg == CFG_HEALTHY && any_trip) begin
            iso_short <= short_in[hit];
            inv_sel   <= INV_W'(hit - IDX_W'(2 * RECT_LEGS));
            if (hit < IDX_W'(RECT_LEGS))
                cfg <= CFG_RECT_A;
            else if (hit < IDX_W'(2 * RECT_LEGS))
                cfg <= CFG_RECT_B;
            else
                cfg <= CFG_INV;
        end
    end
endmodule

// File: rtl/fsup_gate_override.sv
// Gate override network. It maps the configuration onto per-leg upper and
// lower gates, thyristor fire lines and the rectifier-active indication.
// Purely combinational; assumes cmd uses the same leg order as the FSM.
module fsup_gate_override
    import fsup_pkg::*;
#(
    parameter int RECT_LEGS  = 4,
    parameter int INV_LEGS   = 3,
    parameter int PARK_LEG   = 0,
    parameter int BORROW_LEG = 1,
    localparam int NLEG  = 2 * RECT_LEGS + INV_LEGS,
    localparam int INV_W = (INV_LEGS > 1) ? $clog2(INV_LEGS) : 1
) (
    input  cfg_e                cfg,
    input  logic                iso_short,
    input  logic [INV_W-1:0]    inv_sel,
    input  logic [NLEG-1:0]     cmd,
    output logic [NLEG-1:0]     gate_hi,
    output logic [NLEG-1:0]     gate_lo,
    output logic [INV_LEGS-1:0] scr_fire,
    output logic [1:0]          rect_active
);
    // Apply the override for the active configuration on top of pass-through.
    always_comb begin
        gate_hi     = cmd;
        gate_lo     = ~cmd;
        scr_fire    = '0;
        rect_active = 2'b11;
        unique case (cfg)
            CFG_RECT_A: begin
                rect_active = 2'b10;
                for (int i = 0; i < RECT_LEGS; i++) begin
                    gate_hi[i] = iso_short;
                    gate_lo[i] = iso_short;
                end
            end
            CFG_RECT_B: begin
                rect_active = 2'b01;
                for (int i = RECT_LEGS; i < 2 * RECT_LEGS; i++) begin
                    gate_hi[i] = iso_short;
                    gate_lo[i] = iso_short;
                end
            end
            CFG_INV: begin
                rect_active = 2'b01;
                gate_hi[RECT_LEGS + PARK_LEG] = 1'b0;
                gate_lo[RECT_LEGS + PARK_LEG] = 1'b0;
                for (int k = 0; k < INV_LEGS; k++) begin
                    if (inv_sel == INV_W'(k)) begin
                        scr_fire[k]                     = 1'b1;
                        gate_hi[RECT_LEGS + BORROW_LEG] = cmd[2 * RECT_LEGS + k];
                        gate_lo[RECT_LEGS + BORROW_LEG] = ~cmd[2 * RECT_LEGS + k];
                        gate_hi[2 * RECT_LEGS + k]      = 1'b0;
                        gate_lo[2 * RECT_LEGS + k]      = 1'b0;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fault_supervisor.sv
// Top of the converter leg fault supervisor. It holds one monitor per leg,
// the configuration FSM and the gate override network.
// Assumes cmd/meas are sampled each clock and are already synchronous.
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int RECT_LEGS  = 4,
    parameter int INV_LEGS   = 3,
    parameter int TRIP_COUNT = 4,
    parameter int PARK_LEG   = 0,
    parameter int BORROW_LEG = 1,
    localparam int NLEG  = 2 * RECT_LEGS + INV_LEGS,
    localparam int INV_W = (INV_LEGS > 1) ? $clog2(INV_LEGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [NLEG-1:0]     cmd,
    input  logic [NLEG-1:0]     meas,
    output logic [NLEG-1:0]     gate_hi,
    output logic [NLEG-1:0]     gate_lo,
    output logic [INV_LEGS-1:0] scr_fire,
    output logic [1:0]          rect_active,
    output logic [1:0]          cfg,
    output logic [NLEG-1:0]     fault_flag,
    output logic [NLEG-1:0]     fault_short
);
    logic [NLEG-1:0]  trip;
    cfg_e             cfg_q;
    logic             iso_short;
    logic [INV_W-1:0] inv_sel;

    // One hysteresis detector per leg.
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        fsup_leg_monitor #(.TRIP_COUNT(TRIP_COUNT)) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd[g]),
            .meas    (meas[g]),
            .flag    (fault_flag[g]),
            .short_o (fault_short[g]),
            .trip    (trip[g])
        );
    end

    fsup_cfg_fsm #(.RECT_LEGS(RECT_LEGS), .INV_LEGS(INV_LEGS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .trip      (trip),
        .short_in  (fault_short),
        .cfg       (cfg_q),
        .iso_short (iso_short),
        .inv_sel   (inv_sel)
    );

    fsup_gate_override #(
        .RECT_LEGS (RECT_LEGS),
        .INV_LEGS  (INV_LEGS),
        .PARK_LEG  (PARK_LEG),
        .BORROW_LEG(BORROW_LEG)
    ) u_ovr (
        .cfg         (cfg_q),
        .iso_short   (iso_short),
        .inv_sel     (inv_sel),
        .cmd         (cmd),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo),
        .scr_fire    (scr_fire),
        .rect_active (rect_active)
    );

    assign cfg = cfg_q;
endmodule

// File: rtl/fault_supervisor_chk.sv
// Temporal checks on the supervisor's ports, attached with bind below.
module fault_supervisor_chk #(
    parameter int NLEG     = 11,
    parameter int INV_LEGS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic [1:0]          cfg,
    input logic [NLEG-1:0]     cmd,
    input logic [NLEG-1:0]     fault_flag,
    input logic [NLEG-1:0]     gate_hi,
    input logic [NLEG-1:0]     gate_lo,
    input logic [INV_LEGS-1:0] scr_fire
);
    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag != '0) |=> ((fault_flag & $past(fault_flag)) == $past(fault_flag)));
    // R5
    no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'd0 && fault_flag == '0 && !clr) |=> (cfg == 2'd0));
    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != 2'd0 && !clr) |=> (cfg == $past(cfg)));
    // R11
    clr_healthy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cfg == 2'd0));
    // R8
    scr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scr_fire));
    // R8
    scr_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != 2'd3) |-> (scr_fire == '0));
    // R12
    healthy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'd0) |-> (gate_hi == cmd && gate_lo == ~cmd));
endmodule

bind fault_supervisor fault_supervisor_chk #(.NLEG(NLEG), .INV_LEGS(INV_LEGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .cfg        (cfg),
    .cmd        (cmd),
    .fault_flag (fault_flag),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .scr_fire   (scr_fire)
);

// File: tb/fault_supervisor_test.sv
// Sweep bench: every leg faulted with both polarities, plus hysteresis,
// priority and clear scenarios. Expected values are derived from the brief.
module fault_supervisor_test;
    localparam int CLK_P = 10;
    localparam int NL    = 11;
    localparam int TRIP  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [NL-1:0] cmd = '0;
    logic [NL-1:0] meas = '0;
    logic [NL-1:0] gate_hi, gate_lo, fault_flag, fault_short;
    logic [2:0]    scr_fire;
    logic [1:0]    rect_active, cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fault_supervisor uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cmd(cmd), .meas(meas),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .scr_fire(scr_fire),
        .rect_active(rect_active), .cfg(cfg),
        .fault_flag(fault_flag), .fault_short(fault_short)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {gate_hi, gate_lo} from configuration, type, inverter leg, command.
    function automatic logic [2*NL-1:0] exp_gates(int c, bit s, int inv, logic [NL-1:0] cm);
        logic [NL-1:0] hi, lo;
        hi = cm;
        lo = ~cm;
        if (c == 1) for (int i = 0; i < 4; i++) begin hi[i] = s; lo[i] = s; end
        if (c == 2) for (int i = 4; i < 8; i++) begin hi[i] = s; lo[i] = s; end
        if (c == 3) begin
            hi[4] = 1'b0; lo[4] = 1'b0;
            hi[5] = cm[8 + inv]; lo[5] = ~cm[8 + inv];
            hi[8 + inv] = 1'b0; lo[8 + inv] = 1'b0;
        end
        return {hi, lo};
    endfunction

    task automatic drive(logic [NL-1:0] c, logic [NL-1:0] flip);
        cmd  = c;
        meas = c ^ flip;
    endtask

    task automatic do_reset(logic [NL-1:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        clr   = 1'b0;
        drive(c, '0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply TRIP mismatches on one leg; returns command pattern used.
    task automatic fault_leg(int leg, bit s, logic [NL-1:0] base, output logic [NL-1:0] c);
        c = base;
        c[leg] = s;
        for (int k = 0; k < TRIP; k++) begin
            @(negedge clk);
            drive(c, NL'(1) << leg);
        end
        @(negedge clk);
        drive(c, '0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NL-1:0] c, p;
        int ec, inv;
        logic [2*NL-1:0] eg;

        // R1 reset state
        do_reset(11'h2A5);
        #1;
        chk(cfg == 2'd0 && fault_flag == '0 && scr_fire == '0 && rect_active == 2'b11,
            "R1 reset", {cfg, fault_flag, scr_fire, rect_active}, {2'd0, 11'd0, 3'd0, 2'b11});
        chk({gate_hi, gate_lo} == {11'h2A5, ~11'h2A5}, "R12 pass-through",
            {gate_hi, gate_lo}, {11'h2A5, ~11'h2A5});

        // Sweep every leg with both polarities
        for (int leg = 0; leg < NL; leg++) begin
            for (int s = 0; s < 2; s++) begin
                bit early;
                p = NL'(11'h2D5 ^ (leg * 37));
                do_reset(p);
                c = p;
                c[leg] = s[0];
                early = 1'b0;
                for (int k = 0; k < TRIP; k++) begin
                    @(negedge clk);
                    #1;
                    if (fault_flag != '0) early = 1'b1;
                    drive(c, NL'(1) << leg);
                end
                chk(!early, "R2 no flag before trip count", 32'(early), 0);
                @(negedge clk);
                drive(c, '0);
                #1;
                chk(fault_flag == (NL'(1) << leg), "R2 flag at trip count",
                    32'(fault_flag), 32'(NL'(1) << leg));
                chk(fault_short[leg] == s[0], "R4 fault type",
                    32'(fault_short[leg]), 32'(s));
                chk(cfg == 2'd0, "R5 config one edge later", 32'(cfg), 0);
                ec  = (leg < 4) ? 1 : (leg < 8) ? 2 : 3;
                inv = (leg >= 8) ? leg - 8 : 0;
                @(negedge clk);
                #1;
                chk(cfg == 2'(ec), "R5 config code", 32'(cfg), 32'(ec));
                eg = exp_gates(ec, s[0], inv, c);
                chk({gate_hi, gate_lo} == eg, (ec == 3) ? "R8 substitution gates" :
                    (s != 0) ? "R7 short isolation" : "R6 open isolation",
                    32'({gate_hi, gate_lo}), 32'(eg));
                chk(rect_active == ((ec == 1) ? 2'b10 : 2'b01), "R9 rectifier active",
                    32'(rect_active), (ec == 1) ? 2 : 1);
                chk(scr_fire == ((ec == 3) ? 3'(1 << inv) : 3'd0), "R8 thyristor fire",
                    32'(scr_fire), (ec == 3) ? (1 << inv) : 0);
                drive(~c, '0);
                #1;
                eg = exp_gates(ec, s[0], inv, ~c);
                chk({gate_hi, gate_lo} == eg, "R12 overrides under inverted command",
                    32'({gate_hi, gate_lo}), 32'(eg));
            end
        end

        // R3 broken run: M M M match M -> no flag; one more M -> flag
        do_reset(11'h004);
        c = 11'h004;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            drive(c, (k == 3) ? 11'h000 : 11'h004);
        end
        @(negedge clk);
        #1;
        chk(fault_flag == '0, "R3 broken run not tripped", 32'(fault_flag), 0);
        drive(c, 11'h004);
        @(negedge clk);
        #1;
        chk(fault_flag == 11'h004, "R3 broken run trips late", 32'(fault_flag), 32'h4);

        // R3 decay: 3 M, 3 match, 3 M -> still no flag
        do_reset(11'h000);
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            drive(11'h000, (k >= 3 && k < 6) ? 11'h000 : 11'h080);
        end
        @(negedge clk);
        drive(11'h000, '0);
        #1;
        chk(fault_flag == '0, "R3 decay to zero", 32'(fault_flag), 0);

        // R10 first fault wins: inverter leg 9 open, then leg 1 short
        do_reset(11'h000);
        fault_leg(9, 1'b0, 11'h000, c);
        @(negedge clk);
        fault_leg(1, 1'b1, 11'h000, c);
        repeat (2) @(negedge clk);
        #1;
        chk(cfg == 2'd3 && scr_fire == 3'b010, "R10 later fault ignored",
            {cfg, scr_fire}, {2'd3, 3'b010});
        chk(fault_flag == 11'h202, "R10 later fault latched", 32'(fault_flag), 32'h202);

        // R11 clear: healthy, flags kept, then new fault on leg 5
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        drive(11'h155, '0);
        #1;
        chk(cfg == 2'd0 && fault_flag == 11'h202, "R11 clear keeps flags",
            {cfg, fault_flag}, {2'd0, 11'h202});
        chk({gate_hi, gate_lo} == {11'h155, ~11'h155}, "R11 gates pass after clear",
            32'({gate_hi, gate_lo}), 32'({11'h155, ~11'h155}));
        fault_leg(5, 1'b0, 11'h155, c);
        @(negedge clk);
        #1;
        chk(cfg == 2'd2, "R11 new fault after clear", 32'(cfg), 2);

        // R10 simultaneous trips on legs 6 and 3 -> rectifier A
        do_reset(11'h000);
        for (int k = 0; k < TRIP; k++) begin
            @(negedge clk);
            drive(11'h000, 11'h048);
        end
        @(negedge clk);
        drive(11'h000, '0);
        @(negedge clk);
        #1;
        chk(cfg == 2'd1, "R10 lowest index wins", 32'(cfg), 1);
        chk(fault_flag == 11'h048, "R10 both flags latched", 32'(fault_flag), 32'h48);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule